// File: doc/BRIEF.md
# Memory Access Violation Monitor

This block sits behind a memory permission checker and records the first illegal access that the checker reports. When capture is enabled and no earlier event is waiting, a one-cycle violation strobe latches the word offset of the faulting address from a fixed region base, together with the access direction, the world identifier, and either the load/store-versus-fetch kind or the byte enables. A level interrupt is raised and stays high until software clears the event.

Software uses a small register port. The control word holds an enable bit and a clear bit. Clearing works in two steps: software writes the clear bit to 1, which empties the captured state and blocks capture, and then writes it back to 0, which re-arms the monitor. A lock word, once written with 1, freezes the enable bit until reset. The clear bit still works while locked. A parameter selects the instruction-side layout or the data-side layout of the status words.

Top module: `mem_violation_monitor`

## Requirements
- R1: After reset the interrupt is low and the lock, control, status and address words all read 0.
- R2: A violation strobe that arrives while enable (control bit 0) is 1, no event is pending and clear is 0 sets the pending flag (status word bit 0), and the interrupt goes high on the clock edge that samples the strobe.
- R3: The address word (register 3) holds (fault address - region base) >> 2 in its low OFS_W bits. A fault at the base itself reads 0, and a cleared monitor also reads 0.
- R4: While an event is pending, further strobes are dropped and the captured fields do not change.
- R5: While clear (control bit 1) is 1, the pending flag, the interrupt and all captured fields are held at 0 and no capture takes place. After clear is written back to 0, the next strobe is captured.
- R6: While enable is 0, strobes are ignored: the interrupt stays low and the status word stays 0.
- R7: Writing 1 to lock word bit 0 sets a lock that reads back as 1 and stays set until reset. While locked, writes cannot change the enable bit, but they still set and release clear.
- R8: Instruction-side layout (SIDE=0): status word (register 2) bit 1 is the write flag, bits 3:2 the world, and bit 4 is 1 for a load/store and 0 for a fetch. Register 4 reads 0.
- R9: Data-side layout (SIDE=1): status word bits 3:2 are the world, bits 7:4 the byte enables, and bit 8 is the lock state at capture time. Register 4 bit 0 holds the write flag.
- R10: Register read data is registered: it reflects the register chosen by reg_addr at the preceding clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| viol_valid | input | 1 | One-cycle violation strobe from the permission checker |
| viol_addr | input | ADDR_W | Faulting address |
| viol_wr | input | 1 | 1 = write access, 0 = read |
| viol_ls | input | 1 | 1 = load/store, 0 = instruction fetch |
| viol_world | input | WORLD_W | World identifier of the access |
| viol_be | input | BE_W | Byte enables of the access |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select (0 lock, 1 control, 2 status, 3 address, 4 second status) |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Level interrupt, equal to the pending flag |

## Verification
A strobe, a register write or a read each takes effect on the single clock edge that samples it. The interrupt and status therefore change one edge after the strobe, and read data follows one edge after reg_addr is set. A clear bit written at one edge empties the captured state at the next edge, so the bench samples the interrupt only after that second edge. Inputs are driven at falling edges and outputs are sampled at the next falling edge after the edge that is due, so every result is read half a period after it settles. Both layouts run side by side on the same stimulus, and their status words are compared with values packed from the requirement bit positions.

// File: rtl/mvm_pkg.sv
package mvm_pkg;
  localparam int unsigned REG_AW = 3;

  localparam logic [REG_AW-1:0] SEL_LOCK  = 3'd0;
  localparam logic [REG_AW-1:0] SEL_CTRL  = 3'd1;
  localparam logic [REG_AW-1:0] SEL_STAT  = 3'd2;
  localparam logic [REG_AW-1:0] SEL_OFS   = 3'd3;
  localparam logic [REG_AW-1:0] SEL_STAT2 = 3'd4;

  localparam int unsigned CTL_EN_POS  = 0;
  localparam int unsigned CTL_CLR_POS = 1;

  localparam int unsigned SIDE_INSTR = 0;
  localparam int unsigned SIDE_DATA  = 1;
endpackage

// File: rtl/mvm_ctrl_regs.sv
module mvm_ctrl_regs
  import mvm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] sel,
  input  logic              wd_en,
  input  logic              wd_clr,
  output logic              lock_q,
  output logic              en_q,
  output logic              clr_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b0;
      en_q   <= 1'b0;
      clr_q  <= 1'b0;
    end else if (wr_en) begin
      if (sel == SEL_LOCK && wd_en) lock_q <= 1'b1;
      if (sel == SEL_CTRL) begin
        clr_q <= wd_clr;
        if (!lock_q) en_q <= wd_en;
      end
    end
  end

  // R7: the lock is sticky until reset
  a_r7_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q);

  // R7: enable is frozen while locked
  a_r7_en_frozen: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> $stable(en_q));

endmodule

// File: rtl/mvm_capture.sv
module mvm_capture #(
  parameter int unsigned OFS_W   = 16,
  parameter int unsigned WORLD_W = 2,
  parameter int unsigned BE_W    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               strobe,
  input  logic [OFS_W-1:0]   ofs_in,
  input  logic               wr_in,
  input  logic               ls_in,
  input  logic [WORLD_W-1:0] world_in,
  input  logic [BE_W-1:0]    be_in,
  input  logic               lock_in,
  input  logic               en,
  input  logic               clr,
  output logic               pending_q,
  output logic [OFS_W-1:0]   ofs_q,
  output logic               wr_q,
  output logic               ls_q,
  output logic [WORLD_W-1:0] world_q,
  output logic [BE_W-1:0]    be_q,
  output logic               lkst_q
);

  logic take;
  assign take = strobe && en && !pending_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pending_q <= 1'b0;
      ofs_q     <= '0;
      wr_q      <= 1'b0;
      ls_q      <= 1'b0;
      world_q   <= '0;
      be_q      <= '0;
      lkst_q    <= 1'b0;
    end else if (take) begin
      pending_q <= 1'b1;
      ofs_q     <= ofs_in;
      wr_q      <= wr_in;
      ls_q      <= ls_in;
      world_q   <= world_in;
      be_q      <= be_in;
      lkst_q    <= lock_in;
    end
  end

  // R2: an armed strobe is captured at the next edge
  a_r2_capture: assert property (@(posedge clk) disable iff (rst)
    (strobe && en && !pending_q && !clr) |=> (pending_q && ofs_q == $past(ofs_in)));

  // R4: a pending event holds its fields
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (pending_q && !clr) |=> (pending_q && $stable(ofs_q) && $stable(world_q) && $stable(wr_q)));

  // R5: clear empties the captured state
  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!pending_q && ofs_q == '0));

  // R6: no capture while disabled
  a_r6_disabled: assert property (@(posedge clk) disable iff (rst)
    (!en && !pending_q) |=> !pending_q);

endmodule

// File: rtl/mvm_readback.sv
module mvm_readback
  import mvm_pkg::*;
#(
  parameter int unsigned SIDE    = 0,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned OFS_W   = 16,
  parameter int unsigned WORLD_W = 2,
  parameter int unsigned BE_W    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [REG_AW-1:0]  sel,
  input  logic               lock,
  input  logic               en,
  input  logic               clr,
  input  logic               pending,
  input  logic [OFS_W-1:0]   ofs,
  input  logic               wr,
  input  logic               ls,
  input  logic [WORLD_W-1:0] world,
  input  logic [BE_W-1:0]    be,
  input  logic               lkst,
  output logic [DATA_W-1:0]  rdata
);

  localparam int unsigned WORLD_LSB = 2;
  localparam int unsigned KIND_POS  = WORLD_LSB + WORLD_W;
  localparam int unsigned BE_LSB    = WORLD_LSB + WORLD_W;
  localparam int unsigned LKST_POS  = BE_LSB + BE_W;

  logic [DATA_W-1:0] stat_a;
  logic [DATA_W-1:0] stat_b;
  logic [DATA_W-1:0] ctrl_word;
  logic [DATA_W-1:0] ofs_word;
  logic [DATA_W-1:0] lock_word;
  logic [DATA_W-1:0] nxt;

  generate
    if (SIDE == SIDE_INSTR) begin : g_instr
      logic unused_instr;
      assign unused_instr = ^{be, lkst};
      always_comb begin
        stat_a                      = '0;
        stat_a[0]                   = pending;
        stat_a[1]                   = wr;
        stat_a[WORLD_LSB +: WORLD_W] = world;
        stat_a[KIND_POS]            = ls;
        stat_b                      = '0;
      end
    end else begin : g_data
      logic unused_data;
      assign unused_data = ls;
      always_comb begin
        stat_a                      = '0;
        stat_a[0]                   = pending;
        stat_a[WORLD_LSB +: WORLD_W] = world;
        stat_a[BE_LSB +: BE_W]      = be;
        stat_a[LKST_POS]            = lkst;
        stat_b                      = '0;
        stat_b[0]                   = wr;
      end
    end
  endgenerate

  always_comb begin
    ctrl_word              = '0;
    ctrl_word[CTL_EN_POS]  = en;
    ctrl_word[CTL_CLR_POS] = clr;
    ofs_word               = '0;
    ofs_word[OFS_W-1:0]    = ofs;
    lock_word              = '0;
    lock_word[0]           = lock;
    case (sel)
      SEL_LOCK:  nxt = lock_word;
      SEL_CTRL:  nxt = ctrl_word;
      SEL_STAT:  nxt = stat_a;
      SEL_OFS:   nxt = ofs_word;
      SEL_STAT2: nxt = stat_b;
      default:   nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= nxt;
  end

endmodule

// File: rtl/mem_violation_monitor.sv
module mem_violation_monitor
  import mvm_pkg::*;
#(
  parameter int unsigned SIDE    = 0,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned OFS_W   = 16,
  parameter int unsigned WORLD_W = 2,
  parameter int unsigned BE_W    = 4,
  parameter logic [ADDR_W-1:0] REGION_BASE = 32'h2000_0000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               viol_valid,
  input  logic [ADDR_W-1:0]  viol_addr,
  input  logic               viol_wr,
  input  logic               viol_ls,
  input  logic [WORLD_W-1:0] viol_world,
  input  logic [BE_W-1:0]    viol_be,
  input  logic               reg_wr_en,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq
);

  localparam int unsigned OFS_LSB = 2;
  localparam int unsigned OFS_MSB = OFS_LSB + OFS_W - 1;

  logic              lock_q, en_q, clr_q;
  logic              pending_q, wr_q, ls_q, lkst_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [WORLD_W-1:0] world_q;
  logic [BE_W-1:0]   be_q;
  logic [ADDR_W-1:0] diff;
  logic [OFS_W-1:0]  ofs_in;

  assign diff   = viol_addr - REGION_BASE;
  assign ofs_in = diff[OFS_MSB:OFS_LSB];

  logic unused_bits;
  assign unused_bits = ^{diff[OFS_LSB-1:0], diff[ADDR_W-1:OFS_MSB+1],
                         reg_wdata[DATA_W-1:CTL_CLR_POS+1]};

  mvm_ctrl_regs u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (reg_wr_en),
    .sel    (reg_addr),
    .wd_en  (reg_wdata[CTL_EN_POS]),
    .wd_clr (reg_wdata[CTL_CLR_POS]),
    .lock_q (lock_q),
    .en_q   (en_q),
    .clr_q  (clr_q)
  );

  mvm_capture #(
    .OFS_W(OFS_W), .WORLD_W(WORLD_W), .BE_W(BE_W)
  ) u_cap (
    .clk       (clk),
    .rst       (rst),
    .strobe    (viol_valid),
    .ofs_in    (ofs_in),
    .wr_in     (viol_wr),
    .ls_in     (viol_ls),
    .world_in  (viol_world),
    .be_in     (viol_be),
    .lock_in   (lock_q),
    .en        (en_q),
    .clr       (clr_q),
    .pending_q (pending_q),
    .ofs_q     (ofs_q),
    .wr_q      (wr_q),
    .ls_q      (ls_q),
    .world_q   (world_q),
    .be_q      (be_q),
    .lkst_q    (lkst_q)
  );

  mvm_readback #(
    .SIDE(SIDE), .DATA_W(DATA_W), .OFS_W(OFS_W), .WORLD_W(WORLD_W), .BE_W(BE_W)
  ) u_rb (
    .clk     (clk),
    .rst     (rst),
    .sel     (reg_addr),
    .lock    (lock_q),
    .en      (en_q),
    .clr     (clr_q),
    .pending (pending_q),
    .ofs     (ofs_q),
    .wr      (wr_q),
    .ls      (ls_q),
    .world   (world_q),
    .be      (be_q),
    .lkst    (lkst_q),
    .rdata   (reg_rdata)
  );

  assign irq = pending_q;

endmodule

// File: tb/mem_violation_monitor_tb_top.sv
module mem_violation_monitor_tb_top;
  localparam logic [31:0] BASE = 32'h2000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        viol_valid = 1'b0;
  logic [31:0] viol_addr = '0;
  logic        viol_wr = 1'b0;
  logic        viol_ls = 1'b0;
  logic [1:0]  viol_world = '0;
  logic [3:0]  viol_be = '0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata_i, rdata_d;
  logic        irq_i, irq_d;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mem_violation_monitor #(.SIDE(0), .REGION_BASE(BASE)) dut_i (
    .clk(clk), .rst(rst), .viol_valid(viol_valid), .viol_addr(viol_addr),
    .viol_wr(viol_wr), .viol_ls(viol_ls), .viol_world(viol_world), .viol_be(viol_be),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata_i), .irq(irq_i));

  mem_violation_monitor #(.SIDE(1), .REGION_BASE(BASE)) dut_d_i (
    .clk(clk), .rst(rst), .viol_valid(viol_valid), .viol_addr(viol_addr),
    .viol_wr(viol_wr), .viol_ls(viol_ls), .viol_world(viol_world), .viol_be(viol_be),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata_d), .irq(irq_d));

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(logic [2:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    tick();
    reg_wr_en = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_reg(logic [2:0] a, output logic [31:0] vi, output logic [31:0] vd);
    reg_addr = a;
    tick();
    vi = rdata_i; vd = rdata_d;
  endtask

  task automatic strobe(logic [31:0] a, logic w, logic l, logic [1:0] wo, logic [3:0] b);
    viol_addr = a; viol_wr = w; viol_ls = l; viol_world = wo; viol_be = b;
    viol_valid = 1'b1;
    tick();
    viol_valid = 1'b0;
  endtask

  function automatic logic [31:0] stat_i(logic p, logic w, logic [1:0] wo, logic l);
    return {27'd0, l, wo, w, p};
  endfunction

  function automatic logic [31:0] stat_d(logic p, logic [1:0] wo, logic [3:0] b, logic k);
    return {23'd0, k, b, wo, 1'b0, p};
  endfunction

  task automatic t_reset();
    logic [31:0] vi, vd;
    check("R1 irq_i", {31'd0, irq_i}, 0);
    check("R1 irq_d", {31'd0, irq_d}, 0);
    for (int a = 0; a < 5; a++) begin
      rd_reg(a[2:0], vi, vd);
      check("R1 reg_i", vi, 0);
      check("R1 reg_d", vd, 0);
    end
  endtask

  task automatic t_disabled();
    logic [31:0] vi, vd;
    strobe(BASE + 32'h20, 1'b1, 1'b1, 2'd1, 4'hF);
    check("R6 irq_i", {31'd0, irq_i}, 0);
    check("R6 irq_d", {31'd0, irq_d}, 0);
    rd_reg(3'd2, vi, vd);
    check("R6 stat_i", vi, 0);
    check("R6 stat_d", vd, 0);
  endtask

  task automatic t_capture();
    logic [31:0] vi, vd;
    wr_reg(3'd1, 32'd1);
    strobe(BASE + 32'h124, 1'b1, 1'b1, 2'd2, 4'hC);
    check("R2 irq_i", {31'd0, irq_i}, 1);
    check("R2 irq_d", {31'd0, irq_d}, 1);
    rd_reg(3'd3, vi, vd);
    check("R3 ofs_i", vi, 32'h124 >> 2);
    check("R3 ofs_d", vd, 32'h124 >> 2);
    check("R10 read one edge after select", vi, 32'h49);
    rd_reg(3'd2, vi, vd);
    check("R8 stat_i", vi, stat_i(1, 1, 2'd2, 1));
    check("R9 stat_d", vd, stat_d(1, 2'd2, 4'hC, 0));
    rd_reg(3'd4, vi, vd);
    check("R8 stat2_i", vi, 0);
    check("R9 stat2_d", vd, 1);
  endtask

  task automatic t_drop();
    logic [31:0] vi, vd;
    strobe(BASE + 32'h800, 1'b0, 1'b0, 2'd3, 4'h1);
    check("R4 irq_i", {31'd0, irq_i}, 1);
    rd_reg(3'd3, vi, vd);
    check("R4 ofs_i", vi, 32'h49);
    check("R4 ofs_d", vd, 32'h49);
    rd_reg(3'd2, vi, vd);
    check("R4 stat_i", vi, stat_i(1, 1, 2'd2, 1));
    check("R4 stat_d", vd, stat_d(1, 2'd2, 4'hC, 0));
  endtask

  task automatic t_clear();
    logic [31:0] vi, vd;
    wr_reg(3'd1, 32'd3);
    strobe(BASE + 32'h40, 1'b1, 1'b1, 2'd1, 4'h2);
    check("R5 irq_i in clear", {31'd0, irq_i}, 0);
    check("R5 irq_d in clear", {31'd0, irq_d}, 0);
    rd_reg(3'd3, vi, vd);
    check("R5 ofs_i cleared", vi, 0);
    check("R3 zero field after clear", vd, 0);
    rd_reg(3'd2, vi, vd);
    check("R5 stat_i cleared", vi, 0);
    check("R5 stat_d cleared", vd, 0);
    wr_reg(3'd1, 32'd1);
    strobe(BASE + 32'h8, 1'b0, 1'b0, 2'd1, 4'h3);
    check("R5 rearmed irq_i", {31'd0, irq_i}, 1);
    rd_reg(3'd3, vi, vd);
    check("R3 ofs_i second", vi, 2);
    rd_reg(3'd2, vi, vd);
    check("R8 fetch stat_i", vi, stat_i(1, 0, 2'd1, 0));
    check("R9 stat_d second", vd, stat_d(1, 2'd1, 4'h3, 0));
    rd_reg(3'd4, vi, vd);
    check("R9 read flag stat2_d", vd, 0);
  endtask

  task automatic t_lock();
    logic [31:0] vi, vd;
    wr_reg(3'd1, 32'd3);
    wr_reg(3'd1, 32'd1);
    wr_reg(3'd0, 32'd1);
    rd_reg(3'd0, vi, vd);
    check("R7 lock_i", vi, 1);
    check("R7 lock_d", vd, 1);
    wr_reg(3'd1, 32'd0);
    rd_reg(3'd1, vi, vd);
    check("R7 en frozen", vi, 1);
    strobe(BASE + 32'h40, 1'b1, 1'b0, 2'd3, 4'hF);
    check("R7 still enabled irq_d", {31'd0, irq_d}, 1);
    rd_reg(3'd2, vi, vd);
    check("R8 stat_i locked", vi, stat_i(1, 1, 2'd3, 0));
    check("R9 lock state stat_d", vd, stat_d(1, 2'd3, 4'hF, 1));
    rd_reg(3'd3, vi, vd);
    check("R3 ofs_d locked", vd, 32'h10);
    wr_reg(3'd1, 32'd2);
    tick();
    check("R7 clear works when locked", {31'd0, irq_i}, 0);
    rd_reg(3'd1, vi, vd);
    check("R7 ctrl word", vd, 3);
    wr_reg(3'd0, 32'd0);
    rd_reg(3'd0, vi, vd);
    check("R7 lock sticky", vi, 1);
  endtask

  task automatic t_base();
    logic [31:0] vi, vd;
    wr_reg(3'd1, 32'd0);
    strobe(BASE, 1'b1, 1'b1, 2'd0, 4'h1);
    check("R2 irq at base", {31'd0, irq_i}, 1);
    rd_reg(3'd3, vi, vd);
    check("R3 base offset zero", vi, 0);
    rd_reg(3'd2, vi, vd);
    check("R8 stat_i base", vi, stat_i(1, 1, 2'd0, 1));
    check("R9 stat_d base", vd, stat_d(1, 2'd0, 4'h1, 1));
  endtask

  task automatic t_rereset();
    logic [31:0] vi, vd;
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    check("R1 irq after reset", {31'd0, irq_d}, 0);
    rd_reg(3'd0, vi, vd);
    check("R1 lock cleared", vi, 0);
    rd_reg(3'd1, vi, vd);
    check("R1 ctrl cleared", vd, 0);
    rd_reg(3'd2, vi, vd);
    check("R1 stat cleared", vd, 0);
  endtask

  initial begin
    tick(); tick(); tick();
    rst = 1'b0;
    t_reset();
    t_disabled();
    t_capture();
    t_drop();
    t_clear();
    t_lock();
    t_base();
    t_rereset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule